// File: doc/BRIEF.md
# Accumulator Machine Register Bank with Pair Access

This block holds the programmer-visible registers of an 8-bit accumulator machine: the accumulator, six general byte registers that also form three 16-bit pairs, and a 16-bit stack pointer. A sequencer reads it through two byte read ports and one pair read port. It changes it through a single write port that carries an operation code every cycle. The ALU, the flag logic and the sequencer sit outside. The flag bits come in as inputs. When a status word is popped, the flags unpacked from it go out on a port.

Byte codes address the six general registers, the accumulator, or a memory byte at the address held in the HL pair. The memory byte is reached through a small request port, so the sequencer sees memory and registers the same way. Pair codes have two decodings. In normal mode code 3 means the stack pointer. In push mode it means a 16-bit word with the accumulator in the high byte and the packed status byte in the low byte. The write operations are IDLE, BYTE_WR, PAIR_WR, PAIR_INC, PAIR_DEC and SWAP. The operation code chooses which next-state transition the bank takes at the clock edge. In every case the bank returns to the same single holding state.

Top module: `acc_regbank`

## Requirements
- R1: Byte codes select 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 7=A on both byte read ports. A BYTE_WR operation (op code 1) writes the selected register.
- R2: Byte code 6 means the memory byte at address HL. Reading it raises mem_rd_o and returns mem_rdata_i. Writing it raises mem_wr_o with mem_wdata_o equal to wr_data_i[7:0], and no register changes.
- R3: In normal mode, pair codes select 0=BC, 1=DE, 2=HL, 3=SP on the pair read port and for PAIR_WR (op 2), PAIR_INC (op 3) and PAIR_DEC (op 4).
- R4: In push mode, pair code 3 reads {A, status}. The status byte carries sign at bit 7, zero at bit 6, aux carry at bit 4, parity at bit 2 and carry at bit 0, with bit 1 always 1 and bits 3 and 5 always 0. flags_i is ordered {sign, zero, aux, parity, carry}.
- R5: A byte write changes only its half of a pair. B, D and H are high bytes; C, E and L are low bytes.
- R6: SWAP (op 5) exchanges the full 16-bit contents of HL and DE in one cycle.
- R7: PAIR_INC and PAIR_DEC wrap modulo 2^16.
- R8: A PAIR_WR in push mode to code 3 loads A from wr_data_i[15:8] and leaves SP alone. In the same cycle it raises flags_ld_o, with flags_o = {bit7, bit6, bit4, bit2, bit0} of wr_data_i. Bits 1, 3 and 5 are ignored. Push-mode codes 0 to 2 write BC, DE and HL as in normal mode.
- R9: A read of a register written in the same cycle returns the value from before the write.
- R10: Reset (rst_ni low) clears A, all pairs and SP to zero.
- R11: Op codes 0, 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Write operation code |
| wr_byte_sel_i | input | 3 | Byte code for BYTE_WR |
| wr_pair_sel_i | input | 2 | Pair code for PAIR_WR, PAIR_INC, PAIR_DEC |
| wr_push_i | input | 1 | Push-mode decode for PAIR_WR |
| wr_data_i | input | 16 | Write data (byte writes use bits 7:0) |
| rd0_sel_i | input | 3 | Byte code, read port 0 |
| rd0_data_o | output | 8 | Read data, port 0 |
| rd1_sel_i | input | 3 | Byte code, read port 1 |
| rd1_data_o | output | 8 | Read data, port 1 |
| pr_sel_i | input | 2 | Pair code, pair read port |
| pr_push_i | input | 1 | Push-mode decode for pair read |
| pr_data_o | output | 16 | Pair read data |
| flags_i | input | 5 | Current flags {sign, zero, aux, parity, carry} |
| flags_o | output | 5 | Flags unpacked from a popped status word |
| flags_ld_o | output | 1 | flags_o is valid this cycle |
| mem_addr_o | output | 16 | Memory address (HL) |
| mem_rd_o | output | 1 | A read port selects memory |
| mem_rdata_i | input | 8 | Memory read data |
| mem_wr_o | output | 1 | Byte write to memory |
| mem_wdata_o | output | 8 | Memory write data |

## Verification
The bench targets the dual meaning of pair code 3. A design that mixed up the two decodings would overwrite SP on a pop, or show SP where the status word belongs. It checks the fixed status bits under all-zero and all-one flags, because a packer that dropped the constant 1 or leaked flags into bits 3 and 5 would only show up there. It also drives the increment and decrement wrap at 0xFFFF and 0x0000, memory writes through byte code 6 that must leave H and L intact, and half-pair writes that a careless design would spread to the whole pair. It reads a register in the cycle it is written, which exposes any write-through path.

// File: rtl/acc_regbank_pkg.sv
package acc_regbank_pkg;

    localparam int BYTE_W    = 8;
    localparam int PAIR_W    = 2 * BYTE_W;
    localparam int NUM_PAIRS = 4;
    localparam int PSEL_W    = $clog2(NUM_PAIRS);
    localparam int BSEL_W    = PSEL_W + 1;
    localparam int NUM_FLAGS = 5;

    localparam logic [BSEL_W-1:0] BSEL_MEM = 3'd6;
    localparam logic [BSEL_W-1:0] BSEL_ACC = 3'd7;
    localparam logic [PSEL_W-1:0] PSEL_ALT = 2'd3;
    localparam logic [PSEL_W-1:0] PSEL_DE  = 2'd1;
    localparam logic [PSEL_W-1:0] PSEL_HL  = 2'd2;

    localparam int POS_SGN = 7;
    localparam int POS_ZRO = 6;
    localparam int POS_AUX = 4;
    localparam int POS_PAR = 2;
    localparam int POS_ONE = 1;
    localparam int POS_CRY = 0;

    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_BYTE_WR  = 3'd1,
        OP_PAIR_WR  = 3'd2,
        OP_PAIR_INC = 3'd3,
        OP_PAIR_DEC = 3'd4,
        OP_SWAP     = 3'd5
    } op_e;

    typedef struct packed {
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } flags_t;

endpackage

// File: rtl/acc_regbank_status.sv
module acc_regbank_status
    import acc_regbank_pkg::*;
(
    input  flags_t            flags_i,
    output logic [BYTE_W-1:0] status_o
);
    always_comb begin
        status_o          = '0;
        status_o[POS_SGN] = flags_i.sgn;
        status_o[POS_ZRO] = flags_i.zro;
        status_o[POS_AUX] = flags_i.aux;
        status_o[POS_PAR] = flags_i.par;
        status_o[POS_ONE] = 1'b1;
        status_o[POS_CRY] = flags_i.cry;
    end
endmodule

// File: rtl/acc_regbank_bytesel.sv
module acc_regbank_bytesel
    import acc_regbank_pkg::*;
(
    input  logic [BSEL_W-1:0] sel_i,
    input  logic [PAIR_W-1:0] bc_i,
    input  logic [PAIR_W-1:0] de_i,
    input  logic [PAIR_W-1:0] hl_i,
    input  logic [BYTE_W-1:0] acc_i,
    input  logic [BYTE_W-1:0] mem_i,
    output logic [BYTE_W-1:0] data_o,
    output logic              is_mem_o
);
    always_comb begin
        is_mem_o = (sel_i == BSEL_MEM);
        unique case (sel_i)
            3'd0:    data_o = bc_i[PAIR_W-1:BYTE_W];
            3'd1:    data_o = bc_i[BYTE_W-1:0];
            3'd2:    data_o = de_i[PAIR_W-1:BYTE_W];
            3'd3:    data_o = de_i[BYTE_W-1:0];
            3'd4:    data_o = hl_i[PAIR_W-1:BYTE_W];
            3'd5:    data_o = hl_i[BYTE_W-1:0];
            3'd6:    data_o = mem_i;
            default: data_o = acc_i;
        endcase
    end
endmodule

// File: rtl/acc_regbank_store.sv
module acc_regbank_store
    import acc_regbank_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        op_i,
    input  logic [BSEL_W-1:0] byte_sel_i,
    input  logic [PSEL_W-1:0] pair_sel_i,
    input  logic              push_i,
    input  logic [PAIR_W-1:0] wdata_i,
    output logic [PAIR_W-1:0] pair_o [NUM_PAIRS],
    output logic [BYTE_W-1:0] acc_o
);
    logic [PAIR_W-1:0] pair_q [NUM_PAIRS];
    logic [PAIR_W-1:0] pair_d [NUM_PAIRS];
    logic [BYTE_W-1:0] acc_q, acc_d;
    op_e               op;

    assign op = op_e'(op_i);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < NUM_PAIRS; i++) pair_q[i] <= '0;
            acc_q <= '0;
        end else begin
            for (int i = 0; i < NUM_PAIRS; i++) pair_q[i] <= pair_d[i];
            acc_q <= acc_d;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_PAIRS; i++) pair_d[i] = pair_q[i];
        acc_d = acc_q;
        unique case (op)
            OP_BYTE_WR: begin
                if (byte_sel_i == BSEL_ACC) begin
                    acc_d = wdata_i[BYTE_W-1:0];
                end else if (byte_sel_i != BSEL_MEM) begin
                    if (byte_sel_i[0] == 1'b0)
                        pair_d[byte_sel_i[BSEL_W-1:1]][PAIR_W-1:BYTE_W] = wdata_i[BYTE_W-1:0];
                    else
                        pair_d[byte_sel_i[BSEL_W-1:1]][BYTE_W-1:0] = wdata_i[BYTE_W-1:0];
                end
            end
            OP_PAIR_WR: begin
                if (push_i && pair_sel_i == PSEL_ALT)
                    acc_d = wdata_i[PAIR_W-1:BYTE_W];
                else
                    pair_d[pair_sel_i] = wdata_i;
            end
            OP_PAIR_INC: pair_d[pair_sel_i] = pair_q[pair_sel_i] + PAIR_W'(1);
            OP_PAIR_DEC: pair_d[pair_sel_i] = pair_q[pair_sel_i] - PAIR_W'(1);
            OP_SWAP: begin
                pair_d[PSEL_DE] = pair_q[PSEL_HL];
                pair_d[PSEL_HL] = pair_q[PSEL_DE];
            end
            default: ;
        endcase
    end

    always_comb begin
        for (int i = 0; i < NUM_PAIRS; i++) pair_o[i] = pair_q[i];
        acc_o = acc_q;
    end
endmodule

// File: rtl/acc_regbank.sv
module acc_regbank
    import acc_regbank_pkg::*;
#(
    parameter int NUM_RD = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        op_i,
    input  logic [2:0]        wr_byte_sel_i,
    input  logic [1:0]        wr_pair_sel_i,
    input  logic              wr_push_i,
    input  logic [15:0]       wr_data_i,
    input  logic [2:0]        rd0_sel_i,
    output logic [7:0]        rd0_data_o,
    input  logic [2:0]        rd1_sel_i,
    output logic [7:0]        rd1_data_o,
    input  logic [1:0]        pr_sel_i,
    input  logic              pr_push_i,
    output logic [15:0]       pr_data_o,
    input  logic [4:0]        flags_i,
    output logic [4:0]        flags_o,
    output logic              flags_ld_o,
    output logic [15:0]       mem_addr_o,
    output logic              mem_rd_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              mem_wr_o,
    output logic [7:0]        mem_wdata_o
);
    logic [PAIR_W-1:0] pair_w [NUM_PAIRS];
    logic [BYTE_W-1:0] acc_w;
    logic [BYTE_W-1:0] status_w;
    logic [PAIR_W-1:0] hl_w, de_w;
    logic [BSEL_W-1:0] rsel   [NUM_RD];
    logic [BYTE_W-1:0] rdata  [NUM_RD];
    logic [NUM_RD-1:0] rmem;
    flags_t            pop_flags;

    acc_regbank_store u_store (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .op_i       (op_i),
        .byte_sel_i (wr_byte_sel_i),
        .pair_sel_i (wr_pair_sel_i),
        .push_i     (wr_push_i),
        .wdata_i    (wr_data_i),
        .pair_o     (pair_w),
        .acc_o      (acc_w)
    );

    acc_regbank_status u_status (
        .flags_i  (flags_t'(flags_i)),
        .status_o (status_w)
    );

    assign hl_w    = pair_w[PSEL_HL];
    assign de_w    = pair_w[PSEL_DE];
    assign rsel[0] = rd0_sel_i;
    assign rsel[1] = rd1_sel_i;

    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        acc_regbank_bytesel u_sel (
            .sel_i    (rsel[g]),
            .bc_i     (pair_w[0]),
            .de_i     (pair_w[PSEL_DE]),
            .hl_i     (pair_w[PSEL_HL]),
            .acc_i    (acc_w),
            .mem_i    (mem_rdata_i),
            .data_o   (rdata[g]),
            .is_mem_o (rmem[g])
        );
    end

    assign rd0_data_o = rdata[0];
    assign rd1_data_o = rdata[1];
    assign mem_rd_o   = |rmem;
    assign mem_addr_o = hl_w;

    always_comb begin
        if (pr_push_i && pr_sel_i == PSEL_ALT)
            pr_data_o = {acc_w, status_w};
        else
            pr_data_o = pair_w[pr_sel_i];
    end

    always_comb begin
        mem_wr_o      = (op_e'(op_i) == OP_BYTE_WR) && (wr_byte_sel_i == BSEL_MEM);
        mem_wdata_o   = wr_data_i[BYTE_W-1:0];
        flags_ld_o    = (op_e'(op_i) == OP_PAIR_WR) && wr_push_i && (wr_pair_sel_i == PSEL_ALT);
        pop_flags.sgn = wr_data_i[POS_SGN];
        pop_flags.zro = wr_data_i[POS_ZRO];
        pop_flags.aux = wr_data_i[POS_AUX];
        pop_flags.par = wr_data_i[POS_PAR];
        pop_flags.cry = wr_data_i[POS_CRY];
        flags_o       = pop_flags;
    end
endmodule

// File: rtl/acc_regbank_chk.sv
module acc_regbank_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [2:0]  op_i,
    input logic [2:0]  wr_byte_sel_i,
    input logic [1:0]  wr_pair_sel_i,
    input logic [15:0] wr_data_i,
    input logic [2:0]  rd0_sel_i,
    input logic [1:0]  pr_sel_i,
    input logic        pr_push_i,
    input logic [15:0] pr_data_o,
    input logic [4:0]  flags_o,
    input logic        flags_ld_o,
    input logic        mem_rd_o,
    input logic [15:0] hl_w,
    input logic [15:0] de_w
);
    AST_SWAP_PAIRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd5) |=> (hl_w == $past(de_w) && de_w == $past(hl_w))); // R6

    AST_INC_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd3 && wr_pair_sel_i == 2'd2) |=> (hl_w == 16'($past(hl_w) + 16'd1))); // R7

    AST_MEM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd0_sel_i == 3'd6) |-> mem_rd_o); // R2

    AST_STATUS_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pr_push_i && pr_sel_i == 2'd3) |-> (pr_data_o[1] && !pr_data_o[3] && !pr_data_o[5])); // R4

    AST_POP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flags_ld_o |-> (flags_o == {wr_data_i[7], wr_data_i[6], wr_data_i[4], wr_data_i[2], wr_data_i[0]})); // R8

    AST_HALF_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd1 && wr_byte_sel_i == 3'd5) |=> (hl_w[15:8] == $past(hl_w[15:8]))); // R5
endmodule

bind acc_regbank acc_regbank_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .op_i          (op_i),
    .wr_byte_sel_i (wr_byte_sel_i),
    .wr_pair_sel_i (wr_pair_sel_i),
    .wr_data_i     (wr_data_i),
    .rd0_sel_i     (rd0_sel_i),
    .pr_sel_i      (pr_sel_i),
    .pr_push_i     (pr_push_i),
    .pr_data_o     (pr_data_o),
    .flags_o       (flags_o),
    .flags_ld_o    (flags_ld_o),
    .mem_rd_o      (mem_rd_o),
    .hl_w          (hl_w),
    .de_w          (de_w)
);

// File: tb/acc_regbank_bench.sv
`timescale 1ns/1ps
module acc_regbank_bench;
    logic        clk = 1'b0;
    logic        rst_ni;
    logic [2:0]  op_i;
    logic [2:0]  wr_byte_sel_i;
    logic [1:0]  wr_pair_sel_i;
    logic        wr_push_i;
    logic [15:0] wr_data_i;
    logic [2:0]  rd0_sel_i, rd1_sel_i;
    logic [7:0]  rd0_data_o, rd1_data_o;
    logic [1:0]  pr_sel_i;
    logic        pr_push_i;
    logic [15:0] pr_data_o;
    logic [4:0]  flags_i, flags_o;
    logic        flags_ld_o;
    logic [15:0] mem_addr_o;
    logic        mem_rd_o, mem_wr_o;
    logic [7:0]  mem_rdata_i, mem_wdata_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    acc_regbank u_acc_regbank (
        .clk_i(clk), .rst_ni(rst_ni), .op_i(op_i),
        .wr_byte_sel_i(wr_byte_sel_i), .wr_pair_sel_i(wr_pair_sel_i),
        .wr_push_i(wr_push_i), .wr_data_i(wr_data_i),
        .rd0_sel_i(rd0_sel_i), .rd0_data_o(rd0_data_o),
        .rd1_sel_i(rd1_sel_i), .rd1_data_o(rd1_data_o),
        .pr_sel_i(pr_sel_i), .pr_push_i(pr_push_i), .pr_data_o(pr_data_o),
        .flags_i(flags_i), .flags_o(flags_o), .flags_ld_o(flags_ld_o),
        .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_rdata_i(mem_rdata_i),
        .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o)
    );

    // {op, byte_sel, pair_sel, push, data, check_sel, expected}
    localparam logic [35:0] VEC [12] = '{
        {3'd1, 3'd0, 2'd0, 1'b0, 16'h0012, 3'd0, 8'h12},
        {3'd1, 3'd1, 2'd0, 1'b0, 16'h0034, 3'd1, 8'h34},
        {3'd1, 3'd2, 2'd0, 1'b0, 16'h0056, 3'd2, 8'h56},
        {3'd1, 3'd3, 2'd0, 1'b0, 16'h0078, 3'd3, 8'h78},
        {3'd1, 3'd4, 2'd0, 1'b0, 16'h009A, 3'd4, 8'h9A},
        {3'd1, 3'd5, 2'd0, 1'b0, 16'h00BC, 3'd5, 8'hBC},
        {3'd1, 3'd7, 2'd0, 1'b0, 16'h00DE, 3'd7, 8'hDE},
        {3'd2, 3'd0, 2'd0, 1'b0, 16'hA1B2, 3'd1, 8'hB2},
        {3'd3, 3'd0, 2'd2, 1'b0, 16'h0000, 3'd5, 8'hBD},
        {3'd4, 3'd0, 2'd1, 1'b0, 16'h0000, 3'd3, 8'h77},
        {3'd5, 3'd0, 2'd0, 1'b0, 16'h0000, 3'd4, 8'h56},
        {3'd2, 3'd0, 2'd3, 1'b1, 16'h3CFF, 3'd7, 8'h3C}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [2:0] op, input logic [2:0] bs, input logic [1:0] ps,
                         input logic push, input logic [15:0] d);
        op_i = op; wr_byte_sel_i = bs; wr_pair_sel_i = ps; wr_push_i = push; wr_data_i = d;
    endtask

    task automatic rd_pair(input logic [1:0] s, input logic push);
        pr_sel_i = s; pr_push_i = push; #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_ni = 1'b0;
        drive(3'd0, 3'd0, 2'd0, 1'b0, 16'h0);
        rd0_sel_i = 3'd0; rd1_sel_i = 3'd0; pr_sel_i = 2'd0; pr_push_i = 1'b0;
        flags_i = 5'b0; mem_rdata_i = 8'h00;
        repeat (3) tick();
        rst_ni = 1'b1;

        // R10: reset state
        for (int s = 0; s < 8; s++) begin
            if (s != 6) begin
                rd0_sel_i = 3'(s); #1;
                chk("R10 reset byte", {8'h0, rd0_data_o}, 16'h0000);
            end
        end
        rd_pair(2'd3, 1'b0);
        chk("R10 reset SP", pr_data_o, 16'h0000);

        // table walk: R1 R3 R5 R6 R7 R8
        for (int i = 0; i < 12; i++) begin
            logic [35:0] v;
            v = VEC[i];
            drive(v[35:33], v[32:30], v[29:28], v[27], v[26:11]);
            rd0_sel_i = v[10:8];
            tick();
            drive(3'd0, 3'd0, 2'd0, 1'b0, 16'h0);
            #1;
            chk($sformatf("R1 R3 R6 R7 table vector %0d", i), {8'h0, rd0_data_o}, {8'h0, v[7:0]});
        end

        // R9: read during write sees old value
        drive(3'd1, 3'd7, 2'd0, 1'b0, 16'h0055);
        rd0_sel_i = 3'd7; #1;
        chk("R9 old value during write", {8'h0, rd0_data_o}, 16'h003C);
        tick();
        drive(3'd0, 3'd0, 2'd0, 1'b0, 16'h0); #1;
        chk("R1 A after write", {8'h0, rd0_data_o}, 16'h0055);

        // R2: memory at HL
        rd1_sel_i = 3'd6; mem_rdata_i = 8'hA5; #1;
        chk("R2 mem read data", {8'h0, rd1_data_o}, 16'h00A5);
        chk("R2 mem read req", {15'h0, mem_rd_o}, 16'h0001);
        chk("R2 mem addr HL", mem_addr_o, 16'h5677);
        rd1_sel_i = 3'd0;
        drive(3'd1, 3'd6, 2'd0, 1'b0, 16'h0066); #1;
        chk("R2 mem write strobe", {7'h0, mem_wr_o, mem_wdata_o}, 16'h0166);
        tick();
        drive(3'd0, 3'd0, 2'd0, 1'b0, 16'h0);
        rd_pair(2'd2, 1'b0);
        chk("R2 HL untouched by mem write", pr_data_o, 16'h5677);
        rd0_sel_i = 3'd7; #1;
        chk("R2 A untouched by mem write", {8'h0, rd0_data_o}, 16'h0055);

        // R4: status word
        flags_i = 5'b10101; rd_pair(2'd3, 1'b1);
        chk("R4 status mixed", pr_data_o, 16'h5593);
        flags_i = 5'b00000; #1;
        chk("R4 status zero", pr_data_o, 16'h5502);
        flags_i = 5'b11111; #1;
        chk("R4 status ones", pr_data_o, 16'h55D7);

        // R3: pair decode, normal mode
        rd_pair(2'd0, 1'b0); chk("R3 BC", pr_data_o, 16'hA1B2);
        rd_pair(2'd1, 1'b0); chk("R3 DE", pr_data_o, 16'h9ABD);
        rd_pair(2'd2, 1'b0); chk("R3 HL", pr_data_o, 16'h5677);
        rd_pair(2'd3, 1'b0); chk("R3 SP", pr_data_o, 16'h0000);

        // R8: pop into status word
        drive(3'd2, 3'd0, 2'd3, 1'b1, 16'h772A); #1;
        chk("R8 flags ignore reserved bits", {10'h0, flags_ld_o, flags_o}, 16'h0020);
        tick();
        drive(3'd0, 3'd0, 2'd0, 1'b0, 16'h0);
        rd0_sel_i = 3'd7; #1;
        chk("R8 A from pop", {8'h0, rd0_data_o}, 16'h0077);
        rd_pair(2'd3, 1'b0);
        chk("R8 SP untouched by pop", pr_data_o, 16'h0000);
        drive(3'd2, 3'd0, 2'd3, 1'b1, 16'h00D5); #1;
        chk("R8 flags all set", {10'h0, flags_ld_o, flags_o}, 16'h003F);
        tick();
        drive(3'd2, 3'd0, 2'd0, 1'b1, 16'h1234); #1;
        chk("R8 push mode BC no flags", {15'h0, flags_ld_o}, 16'h0000);
        tick();
        drive(3'd0, 3'd0, 2'd0, 1'b0, 16'h0);
        rd_pair(2'd0, 1'b0);
        chk("R8 push mode code 0 writes BC", pr_data_o, 16'h1234);

        // R7: wrap
        drive(3'd2, 3'd0, 2'd3, 1'b0, 16'hFFFF); tick();
        drive(3'd3, 3'd0, 2'd3, 1'b0, 16'h0); tick();
        drive(3'd0, 3'd0, 2'd0, 1'b0, 16'h0);
        rd_pair(2'd3, 1'b0);
        chk("R7 inc wraps", pr_data_o, 16'h0000);
        drive(3'd4, 3'd0, 2'd3, 1'b0, 16'h0); tick();
        drive(3'd0, 3'd0, 2'd0, 1'b0, 16'h0); #1;
        chk("R7 dec wraps", pr_data_o, 16'hFFFF);

        // R5: half writes
        drive(3'd1, 3'd4, 2'd0, 1'b0, 16'hEE11); tick();
        drive(3'd1, 3'd1, 2'd0, 1'b0, 16'h0001); tick();
        drive(3'd0, 3'd0, 2'd0, 1'b0, 16'h0);
        rd_pair(2'd2, 1'b0);
        chk("R5 H only", pr_data_o, 16'h1177);
        rd_pair(2'd0, 1'b0);
        chk("R5 C only", pr_data_o, 16'h1201);

        // R11: undefined op codes
        drive(3'd6, 3'd0, 2'd0, 1'b0, 16'hFFFF); tick();
        drive(3'd7, 3'd0, 2'd0, 1'b0, 16'hFFFF); tick();
        drive(3'd0, 3'd0, 2'd0, 1'b0, 16'h0);
        rd_pair(2'd0, 1'b0);
        chk("R11 BC unchanged", pr_data_o, 16'h1201);
        rd0_sel_i = 3'd7; #1;
        chk("R11 A unchanged", {8'h0, rd0_data_o}, 16'h0000);

        // R10: reset again
        rst_ni = 1'b0; tick(); rst_ni = 1'b1;
        rd_pair(2'd2, 1'b0);
        chk("R10 HL cleared", pr_data_o, 16'h0000);

        finish_run();
    end
endmodule